// File: doc/BRIEF.md
# Dual-Box Ray Intersection Pipeline

This block tests one ray against both child bounding boxes of a binary bounding-volume-hierarchy node. Each cycle it can take one ray and one node. It returns, for each child, whether the ray crosses the box and at what distance the ray enters it. It also passes along the two child links and a flag that tells the traversal logic which child to visit first. Fetching nodes, keeping the traversal stack and testing triangles are all left to neighbouring blocks.

The unit works on one ray at a time, not on one instruction across a group of rays. A ray that leaves traversal early or turns to triangle work therefore frees its slot for the next ray, and no arithmetic lane sits idle. The first stage forms all twelve slab distances of a node at once, as (plane − origin) × inverse direction for both boxes. The second stage reduces these to an entry and exit distance per box. The third stage decides hit or miss and the visit order.

All values are signed fixed point. Coordinates, inverse directions and the ray's distance limits are Q8.8. Distances come out at full product width, with 16 fractional bits. The input and the output each use a valid/ready handshake. A stalled output freezes the whole pipe.

Top module: `rayx_dual_box_test`

## Requirements
- R1: For each box and axis the slab distances are (plane − origin) × inverse direction, exact in a 33-bit signed result with 16 fractional bits. The axis near value is the smaller of the two and the far value the larger. The reported entry distance is the largest of the three near values and the ray minimum distance shifted left by 8.
- R2: A box is hit exactly when its entry distance is less than or equal to its exit distance. The exit distance is the smallest of the three far values and the ray maximum distance shifted left by 8. A ray that only touches a box (entry equal to exit) counts as a hit.
- R3: The node arrives as one word. The coordinate of box b (0 or 1), corner k (0 = minimum, 1 = maximum) and axis a (0 = x, 1 = y, 2 = z) sits at bits [16*(6b+3k+a) +: 16]. Link 0 sits at [192 +: 32] and link 1 at [224 +: 32]. The ray origin and the inverse direction place axis a at [16a +: 16]. Both boxes are tested against the same ray in one transaction, each on its own.
- R4: The swap output is 1 only when both boxes are hit and the entry distance of box 1 is strictly smaller than that of box 0. On equal entry distances child 0 stays first.
- R5: The tag and both child links come out unchanged and in input order. The swap output only tells the visit order; it does not reorder them.
- R6: A transaction accepted in cycle n (in_valid and in_ready both high) shows at the output with out_valid high in cycle n+3. Each cycle in which out_valid is high and out_ready is low adds one cycle.
- R7: While out_valid is high and out_ready is low, every output holds still and no new transaction is taken in. Each accepted transaction leaves exactly once, in order of acceptance.
- R8: With out_ready held high, in_ready stays high, so one transaction is taken in every cycle.
- R9: The extreme input values 0x8000 and 0x7FFF give exact distances, with no wrap.
- R10: During reset and in the first cycle after it, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid_i | input | 1 | Request present |
| in_ready_o | output | 1 | Request taken when high together with in_valid_i |
| ray_org_i | input | 48 | Ray origin, three Q8.8 values |
| ray_inv_i | input | 48 | Ray inverse direction, three Q8.8 values |
| ray_tmin_i | input | 16 | Ray minimum distance, Q8.8 |
| ray_tmax_i | input | 16 | Ray maximum distance, Q8.8 |
| ray_tag_i | input | 8 | Request tag |
| node_i | input | 256 | Two boxes and two child links |
| out_valid_o | output | 1 | Result present |
| out_ready_i | input | 1 | Consumer takes the result |
| out_tag_o | output | 8 | Tag of the result |
| out_hit_o | output | 2 | Bit b set when box b is hit |
| out_swap_o | output | 1 | Visit child 1 first |
| out_entry0_o | output | 33 | Entry distance of box 0 |
| out_entry1_o | output | 33 | Entry distance of box 1 |
| out_link0_o | output | 32 | Child link 0 |
| out_link1_o | output | 32 | Child link 1 |

## Verification
A product slice wired to the wrong axis or box shows up as a wrong entry distance or hit flag three cycles after that request is accepted. Random boxes reach every slot, so such a slice is found within the first few hundred requests. A stage register that ignores the stall shows up in the first frozen cycle, as a changed output or a result that is lost or appears twice against the scoreboard's queue. A wrong tie rule in the visit order shows up as a wrong swap flag on the directed equal-entry request.

// File: rtl/rayx_pkg.sv
package rayx_pkg;
   localparam int unsigned NUM_BOX         = 2;
   localparam int unsigned NUM_CORNER      = 2;
   localparam int unsigned NUM_AXIS        = 3;
   localparam int unsigned COORDS_PER_NODE = NUM_BOX * NUM_CORNER * NUM_AXIS;

   // position of one coordinate inside the node word, in coordinate units
   function automatic int unsigned coord_slot(input int unsigned box,
                                              input int unsigned corner,
                                              input int unsigned axis);
      return (box * NUM_CORNER + corner) * NUM_AXIS + axis;
   endfunction
endpackage

// File: rtl/rayx_slab_mac.sv
module rayx_slab_mac
   import rayx_pkg::*;
#(
   parameter int unsigned COORD_W = 16,
   parameter int unsigned FRAC_W  = 8,
   parameter int unsigned TAG_W   = 8,
   parameter int unsigned LINK_W  = 32,
   localparam int unsigned DIFF_W = COORD_W + 1,
   localparam int unsigned PROD_W = DIFF_W + COORD_W,
   localparam int unsigned NODE_W = COORDS_PER_NODE * COORD_W + 2 * LINK_W
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               en,
   input  logic                               valid_i,
   input  logic [NUM_AXIS*COORD_W-1:0]        org_i,
   input  logic [NUM_AXIS*COORD_W-1:0]        inv_i,
   input  logic [COORD_W-1:0]                 tmin_i,
   input  logic [COORD_W-1:0]                 tmax_i,
   input  logic [TAG_W-1:0]                   tag_i,
   input  logic [NODE_W-1:0]                  node_i,
   output logic                               valid_o,
   output logic [COORDS_PER_NODE*PROD_W-1:0]  prod_o,
   output logic signed [PROD_W-1:0]           tmin_o,
   output logic signed [PROD_W-1:0]           tmax_o,
   output logic [TAG_W-1:0]                   tag_o,
   output logic [LINK_W-1:0]                  link0_o,
   output logic [LINK_W-1:0]                  link1_o
);
   localparam int unsigned PAD_W     = PROD_W - COORD_W - FRAC_W;
   localparam int unsigned LINK0_LSB = COORDS_PER_NODE * COORD_W;
   localparam int unsigned LINK1_LSB = LINK0_LSB + LINK_W;

   logic [COORDS_PER_NODE*PROD_W-1:0] prod_d;
   logic signed [PROD_W-1:0]          tmin_d, tmax_d;

   // twelve slab distances side by side
   for (genvar b = 0; b < NUM_BOX; b++) begin : g_box
      for (genvar k = 0; k < NUM_CORNER; k++) begin : g_corner
         for (genvar a = 0; a < NUM_AXIS; a++) begin : g_axis
            localparam int unsigned SLOT = coord_slot(b, k, a);
            localparam int unsigned PLO  = SLOT * COORD_W;
            localparam int unsigned ALO  = a * COORD_W;
            logic signed [DIFF_W-1:0]  plane_s, org_s, diff;
            logic signed [COORD_W-1:0] inv_s;
            logic signed [PROD_W-1:0]  prod;
            assign plane_s = $signed({node_i[PLO+COORD_W-1], node_i[PLO +: COORD_W]});
            assign org_s   = $signed({org_i[ALO+COORD_W-1], org_i[ALO +: COORD_W]});
            assign inv_s   = $signed(inv_i[ALO +: COORD_W]);
            assign diff    = plane_s - org_s;
            assign prod    = PROD_W'(diff) * PROD_W'(inv_s);
            assign prod_d[SLOT*PROD_W +: PROD_W] = prod;
         end
      end
   end

   // ray limits brought to the product scale
   assign tmin_d = $signed({{PAD_W{tmin_i[COORD_W-1]}}, tmin_i, {FRAC_W{1'b0}}});
   assign tmax_d = $signed({{PAD_W{tmax_i[COORD_W-1]}}, tmax_i, {FRAC_W{1'b0}}});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
      end else if (en) begin
         valid_o <= valid_i;
      end
   end

   always_ff @(posedge clk) begin
      if (en) begin
         prod_o  <= prod_d;
         tmin_o  <= tmin_d;
         tmax_o  <= tmax_d;
         tag_o   <= tag_i;
         link0_o <= node_i[LINK0_LSB +: LINK_W];
         link1_o <= node_i[LINK1_LSB +: LINK_W];
      end
   end
endmodule

// File: rtl/rayx_span_reduce.sv
module rayx_span_reduce
   import rayx_pkg::*;
#(
   parameter int unsigned PROD_W = 33,
   parameter int unsigned TAG_W  = 8,
   parameter int unsigned LINK_W = 32
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               en,
   input  logic                               valid_i,
   input  logic [COORDS_PER_NODE*PROD_W-1:0]  prod_i,
   input  logic signed [PROD_W-1:0]           tmin_i,
   input  logic signed [PROD_W-1:0]           tmax_i,
   input  logic [TAG_W-1:0]                   tag_i,
   input  logic [LINK_W-1:0]                  link0_i,
   input  logic [LINK_W-1:0]                  link1_i,
   output logic                               valid_o,
   output logic [NUM_BOX*PROD_W-1:0]          entry_o,
   output logic [NUM_BOX*PROD_W-1:0]          exit_o,
   output logic [TAG_W-1:0]                   tag_o,
   output logic [LINK_W-1:0]                  link0_o,
   output logic [LINK_W-1:0]                  link1_o
);
   logic [NUM_BOX*PROD_W-1:0] entry_d, exit_d;

   for (genvar b = 0; b < NUM_BOX; b++) begin : g_box
      logic signed [PROD_W-1:0] near_ax [NUM_AXIS];
      logic signed [PROD_W-1:0] far_ax  [NUM_AXIS];
      logic signed [PROD_W-1:0] entry_b, exit_b;

      for (genvar a = 0; a < NUM_AXIS; a++) begin : g_axis
         logic signed [PROD_W-1:0] t_lo, t_hi;
         assign t_lo = prod_i[coord_slot(b, 0, a)*PROD_W +: PROD_W];
         assign t_hi = prod_i[coord_slot(b, 1, a)*PROD_W +: PROD_W];
         // slab order depends on the sign of the inverse direction
         assign near_ax[a] = (t_lo < t_hi) ? t_lo : t_hi;
         assign far_ax[a]  = (t_lo < t_hi) ? t_hi : t_lo;
      end

      always_comb begin
         entry_b = tmin_i;
         exit_b  = tmax_i;
         for (int a = 0; a < NUM_AXIS; a++) begin
            if (near_ax[a] > entry_b) entry_b = near_ax[a];
            if (far_ax[a]  < exit_b)  exit_b  = far_ax[a];
         end
      end

      assign entry_d[b*PROD_W +: PROD_W] = entry_b;
      assign exit_d[b*PROD_W +: PROD_W]  = exit_b;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
      end else if (en) begin
         valid_o <= valid_i;
      end
   end

   always_ff @(posedge clk) begin
      if (en) begin
         entry_o <= entry_d;
         exit_o  <= exit_d;
         tag_o   <= tag_i;
         link0_o <= link0_i;
         link1_o <= link1_i;
      end
   end
endmodule

// File: rtl/rayx_order_select.sv
module rayx_order_select
   import rayx_pkg::*;
#(
   parameter int unsigned PROD_W = 33,
   parameter int unsigned TAG_W  = 8,
   parameter int unsigned LINK_W = 32
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        en,
   input  logic                        valid_i,
   input  logic [NUM_BOX*PROD_W-1:0]   entry_i,
   input  logic [NUM_BOX*PROD_W-1:0]   exit_i,
   input  logic [TAG_W-1:0]            tag_i,
   input  logic [LINK_W-1:0]           link0_i,
   input  logic [LINK_W-1:0]           link1_i,
   output logic                        valid_o,
   output logic [NUM_BOX-1:0]          hit_o,
   output logic                        swap_o,
   output logic [PROD_W-1:0]           entry0_o,
   output logic [PROD_W-1:0]           entry1_o,
   output logic [TAG_W-1:0]            tag_o,
   output logic [LINK_W-1:0]           link0_o,
   output logic [LINK_W-1:0]           link1_o
);
   logic [NUM_BOX-1:0]       hit_d;
   logic signed [PROD_W-1:0] ent0, ent1;
   logic                     swap_d;

   for (genvar b = 0; b < NUM_BOX; b++) begin : g_box
      logic signed [PROD_W-1:0] ent_b, ext_b;
      assign ent_b    = entry_i[b*PROD_W +: PROD_W];
      assign ext_b    = exit_i[b*PROD_W +: PROD_W];
      assign hit_d[b] = (ent_b <= ext_b);
   end

   assign ent0   = entry_i[0 +: PROD_W];
   assign ent1   = entry_i[PROD_W +: PROD_W];
   // strict compare keeps child 0 first on a tie
   assign swap_d = (&hit_d) && (ent1 < ent0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
      end else if (en) begin
         valid_o <= valid_i;
      end
   end

   always_ff @(posedge clk) begin
      if (en) begin
         hit_o    <= hit_d;
         swap_o   <= swap_d;
         entry0_o <= ent0;
         entry1_o <= ent1;
         tag_o    <= tag_i;
         link0_o  <= link0_i;
         link1_o  <= link1_i;
      end
   end
endmodule

// File: rtl/rayx_dual_box_test.sv
module rayx_dual_box_test
   import rayx_pkg::*;
#(
   parameter int unsigned COORD_W     = 16,
   parameter int unsigned FRAC_W      = 8,
   parameter int unsigned TAG_W       = 8,
   parameter int unsigned LINK_W      = 32,
   parameter int unsigned RECORD_BITS = 512,
   localparam int unsigned DIFF_W = COORD_W + 1,
   localparam int unsigned PROD_W = DIFF_W + COORD_W,
   localparam int unsigned NODE_W = COORDS_PER_NODE * COORD_W + 2 * LINK_W,
   localparam int unsigned VEC_W  = NUM_AXIS * COORD_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid_i,
   output logic                in_ready_o,
   input  logic [VEC_W-1:0]    ray_org_i,
   input  logic [VEC_W-1:0]    ray_inv_i,
   input  logic [COORD_W-1:0]  ray_tmin_i,
   input  logic [COORD_W-1:0]  ray_tmax_i,
   input  logic [TAG_W-1:0]    ray_tag_i,
   input  logic [NODE_W-1:0]   node_i,
   output logic                out_valid_o,
   input  logic                out_ready_i,
   output logic [TAG_W-1:0]    out_tag_o,
   output logic [NUM_BOX-1:0]  out_hit_o,
   output logic                out_swap_o,
   output logic [PROD_W-1:0]   out_entry0_o,
   output logic [PROD_W-1:0]   out_entry1_o,
   output logic [LINK_W-1:0]   out_link0_o,
   output logic [LINK_W-1:0]   out_link1_o
);
   if (FRAC_W == 0 || FRAC_W >= COORD_W) begin : g_bad_frac
      $error("rayx_dual_box_test: FRAC_W must lie between 1 and COORD_W-1");
   end
   if (NODE_W > RECORD_BITS) begin : g_bad_record
      $error("rayx_dual_box_test: node fields exceed the record size");
   end
   if (TAG_W == 0 || LINK_W == 0) begin : g_bad_side
      $error("rayx_dual_box_test: tag and link widths must be nonzero");
   end

   logic en;

   logic                              s1_valid;
   logic [COORDS_PER_NODE*PROD_W-1:0] s1_prod;
   logic signed [PROD_W-1:0]          s1_tmin, s1_tmax;
   logic [TAG_W-1:0]                  s1_tag;
   logic [LINK_W-1:0]                 s1_link0, s1_link1;

   logic                      s2_valid;
   logic [NUM_BOX*PROD_W-1:0] s2_entry, s2_exit;
   logic [TAG_W-1:0]          s2_tag;
   logic [LINK_W-1:0]         s2_link0, s2_link1;

   // one enable for every stage: the pipe moves unless the result is held
   assign en         = !out_valid_o || out_ready_i;
   assign in_ready_o = en;

   rayx_slab_mac #(
      .COORD_W(COORD_W), .FRAC_W(FRAC_W), .TAG_W(TAG_W), .LINK_W(LINK_W)
   ) i_mac (
      .clk(clk), .rst_n(rst_n), .en(en), .valid_i(in_valid_i),
      .org_i(ray_org_i), .inv_i(ray_inv_i),
      .tmin_i(ray_tmin_i), .tmax_i(ray_tmax_i),
      .tag_i(ray_tag_i), .node_i(node_i),
      .valid_o(s1_valid), .prod_o(s1_prod),
      .tmin_o(s1_tmin), .tmax_o(s1_tmax), .tag_o(s1_tag),
      .link0_o(s1_link0), .link1_o(s1_link1)
   );

   rayx_span_reduce #(
      .PROD_W(PROD_W), .TAG_W(TAG_W), .LINK_W(LINK_W)
   ) i_span (
      .clk(clk), .rst_n(rst_n), .en(en), .valid_i(s1_valid),
      .prod_i(s1_prod), .tmin_i(s1_tmin), .tmax_i(s1_tmax),
      .tag_i(s1_tag), .link0_i(s1_link0), .link1_i(s1_link1),
      .valid_o(s2_valid), .entry_o(s2_entry), .exit_o(s2_exit),
      .tag_o(s2_tag), .link0_o(s2_link0), .link1_o(s2_link1)
   );

   rayx_order_select #(
      .PROD_W(PROD_W), .TAG_W(TAG_W), .LINK_W(LINK_W)
   ) i_order (
      .clk(clk), .rst_n(rst_n), .en(en), .valid_i(s2_valid),
      .entry_i(s2_entry), .exit_i(s2_exit),
      .tag_i(s2_tag), .link0_i(s2_link0), .link1_i(s2_link1),
      .valid_o(out_valid_o), .hit_o(out_hit_o), .swap_o(out_swap_o),
      .entry0_o(out_entry0_o), .entry1_o(out_entry1_o),
      .tag_o(out_tag_o), .link0_o(out_link0_o), .link1_o(out_link1_o)
   );
endmodule

// File: rtl/rayx_dual_box_test_chk.sv
module rayx_dual_box_test_chk
   import rayx_pkg::*;
#(
   parameter int unsigned PROD_W = 33,
   parameter int unsigned TAG_W  = 8,
   parameter int unsigned LINK_W = 32
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      en,
   input logic                      in_valid_i,
   input logic                      in_ready_o,
   input logic [TAG_W-1:0]          ray_tag_i,
   input logic                      s1_valid,
   input logic [TAG_W-1:0]          s1_tag,
   input logic                      s2_valid,
   input logic [NUM_BOX*PROD_W-1:0] s2_entry,
   input logic [NUM_BOX*PROD_W-1:0] s2_exit,
   input logic                      out_valid_o,
   input logic                      out_ready_i,
   input logic [TAG_W-1:0]          out_tag_o,
   input logic [NUM_BOX-1:0]        out_hit_o,
   input logic                      out_swap_o,
   input logic [PROD_W-1:0]         out_entry0_o,
   input logic [PROD_W-1:0]         out_entry1_o,
   input logic [LINK_W-1:0]         out_link0_o,
   input logic [LINK_W-1:0]         out_link1_o
);
   // R10
   reset_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> !out_valid_o);

   // R7
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_tag_o)
         && $stable(out_hit_o) && $stable(out_swap_o) && $stable(out_entry0_o)
         && $stable(out_entry1_o) && $stable(out_link0_o) && $stable(out_link1_o));

   // R7
   stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid_o && !out_ready_i |-> !in_ready_o);

   // R4
   swap_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid_o && out_swap_o |-> (out_hit_o == 2'b11)
         && ($signed(out_entry1_o) < $signed(out_entry0_o)));

   // R4
   tie_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid_o && (out_entry0_o == out_entry1_o) |-> !out_swap_o);

   // R2
   hit_box0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en && s2_valid |=> out_hit_o[0] == ($signed($past(s2_entry[0 +: PROD_W]))
         <= $signed($past(s2_exit[0 +: PROD_W]))));

   // R2
   hit_box1_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en && s2_valid |=> out_hit_o[1] == ($signed($past(s2_entry[PROD_W +: PROD_W]))
         <= $signed($past(s2_exit[PROD_W +: PROD_W]))));

   // R6
   accept_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid_i && in_ready_o |=> s1_valid && (s1_tag == $past(ray_tag_i)));
endmodule

bind rayx_dual_box_test rayx_dual_box_test_chk #(
   .PROD_W(PROD_W), .TAG_W(TAG_W), .LINK_W(LINK_W)
) i_chk (
   .clk(clk), .rst_n(rst_n), .en(en),
   .in_valid_i(in_valid_i), .in_ready_o(in_ready_o), .ray_tag_i(ray_tag_i),
   .s1_valid(s1_valid), .s1_tag(s1_tag),
   .s2_valid(s2_valid), .s2_entry(s2_entry), .s2_exit(s2_exit),
   .out_valid_o(out_valid_o), .out_ready_i(out_ready_i), .out_tag_o(out_tag_o),
   .out_hit_o(out_hit_o), .out_swap_o(out_swap_o),
   .out_entry0_o(out_entry0_o), .out_entry1_o(out_entry1_o),
   .out_link0_o(out_link0_o), .out_link1_o(out_link1_o)
);

// File: tb/test_rayx_dual_box_test.sv
module test_rayx_dual_box_test;
   localparam int PW = 33;

   typedef struct packed {
      logic [2:0][15:0]  org;
      logic [2:0][15:0]  inv;
      logic [11:0][15:0] pl;
      logic [15:0]       tmin;
      logic [15:0]       tmax;
      logic [7:0]        tag;
      logic [31:0]       lk0;
      logic [31:0]       lk1;
   } stim_t;

   typedef struct packed {
      logic [7:0]         tag;
      logic [1:0]         hit;
      logic               swap;
      logic signed [63:0] e0;
      logic signed [63:0] e1;
      logic [31:0]        lk0;
      logic [31:0]        lk1;
      int                 acc;
      int                 frz;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic          in_ready;
   logic [47:0]   ray_org = '0, ray_inv = '0;
   logic [15:0]   ray_tmin = '0, ray_tmax = '0;
   logic [7:0]    ray_tag = '0;
   logic [255:0]  node = '0;
   logic          out_valid;
   logic          out_ready = 1'b1;
   logic [7:0]    out_tag;
   logic [1:0]    out_hit;
   logic          out_swap;
   logic [PW-1:0] out_e0, out_e1;
   logic [31:0]   out_lk0, out_lk1;

   int errors = 0, checks = 0;
   int cyc = 0, frz_cnt = 0;
   int pushed = 0, popped = 0;
   int ready_mode = 0;
   int gap_pct = 0;
   bit loaded = 1'b0;
   bit hold_seen = 1'b0;
   logic [7:0]  hold_tag;
   logic [PW-1:0] hold_e0;
   stim_t cur;
   stim_t stim_q[$];
   exp_t  exp_q[$];

   always #10 clk = ~clk;

   rayx_dual_box_test i_rayx_dual_box_test (
      .clk(clk), .rst_n(rst_n),
      .in_valid_i(in_valid), .in_ready_o(in_ready),
      .ray_org_i(ray_org), .ray_inv_i(ray_inv),
      .ray_tmin_i(ray_tmin), .ray_tmax_i(ray_tmax), .ray_tag_i(ray_tag),
      .node_i(node),
      .out_valid_o(out_valid), .out_ready_i(out_ready),
      .out_tag_o(out_tag), .out_hit_o(out_hit), .out_swap_o(out_swap),
      .out_entry0_o(out_e0), .out_entry1_o(out_e1),
      .out_link0_o(out_lk0), .out_link1_o(out_lk1)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   // model of R1/R2 for one box
   function automatic void ref_box(input stim_t s, input int b,
                                   output logic h, output longint e);
      longint ent, ext, t0, t1, nr, fr;
      ent = longint'($signed(s.tmin)) * 256;
      ext = longint'($signed(s.tmax)) * 256;
      for (int a = 0; a < 3; a++) begin
         t0 = (longint'($signed(s.pl[b*6+a])) - longint'($signed(s.org[a])))
              * longint'($signed(s.inv[a]));
         t1 = (longint'($signed(s.pl[b*6+3+a])) - longint'($signed(s.org[a])))
              * longint'($signed(s.inv[a]));
         nr = (t0 < t1) ? t0 : t1;
         fr = (t0 < t1) ? t1 : t0;
         if (nr > ent) ent = nr;
         if (fr < ext) ext = fr;
      end
      h = (ent <= ext);
      e = ent;
   endfunction

   // driver side: expected item for an accepted request
   task automatic push_expected(input stim_t s);
      exp_t x;
      logic h0, h1;
      longint e0, e1;
      ref_box(s, 0, h0, e0);
      ref_box(s, 1, h1, e1);
      x.tag  = s.tag;
      x.hit  = {h1, h0};
      x.swap = h0 && h1 && (e1 < e0);
      x.e0   = e0;
      x.e1   = e1;
      x.lk0  = s.lk0;
      x.lk1  = s.lk1;
      x.acc  = cyc;
      x.frz  = frz_cnt;
      exp_q.push_back(x);
      pushed++;
   endtask

   // monitor side: compare the result leaving this cycle
   task automatic pop_compare();
      exp_t x;
      longint g0, g1;
      if (exp_q.size() == 0) begin
         check(1'b0, "R7", "result without request", popped, pushed);
         return;
      end
      x = exp_q.pop_front();
      popped++;
      g0 = longint'($signed(out_e0));
      g1 = longint'($signed(out_e1));
      check(g0 == x.e0, "R1", "entry box0", g0, x.e0);
      check(g1 == x.e1, "R3", "entry box1", g1, x.e1);
      check(out_hit == x.hit, "R2", "hit flags", out_hit, x.hit);
      check(out_swap == x.swap, "R4", "swap", out_swap, x.swap);
      check(out_tag == x.tag && out_lk0 == x.lk0 && out_lk1 == x.lk1,
            "R5", "tag/links", {out_tag, out_lk0[7:0]}, {x.tag, x.lk0[7:0]});
      check(cyc - x.acc == 3 + (frz_cnt - x.frz), "R6", "latency",
            cyc - x.acc, 3 + (frz_cnt - x.frz));
   endtask

   task automatic step();
      @(negedge clk);
      cyc++;
      out_ready = (ready_mode == 0) ? 1'b1 : ($urandom_range(0, 99) < 60);
      if (!loaded) begin
         if (stim_q.size() > 0 && $urandom_range(0, 99) >= gap_pct) begin
            cur = stim_q.pop_front();
            loaded = 1'b1;
         end
      end
      in_valid = loaded;
      ray_org  = cur.org;
      ray_inv  = cur.inv;
      ray_tmin = cur.tmin;
      ray_tmax = cur.tmax;
      ray_tag  = cur.tag;
      node     = {cur.lk1, cur.lk0, cur.pl};
      #1;
      if (hold_seen) begin
         check(out_valid && out_tag == hold_tag && out_e0 == hold_e0,
               "R7", "held output", out_tag, hold_tag);
         hold_seen = 1'b0;
      end
      if (ready_mode == 0 && in_valid)
         check(in_ready == 1'b1, "R8", "in_ready under open output", in_ready, 1);
      if (out_valid && out_ready) pop_compare();
      if (in_valid && in_ready) begin
         push_expected(cur);
         loaded = 1'b0;
      end
      if (out_valid && !out_ready) begin
         frz_cnt++;
         check(in_ready == 1'b0, "R7", "in_ready while held", in_ready, 0);
         hold_seen = 1'b1;
         hold_tag  = out_tag;
         hold_e0   = out_e0;
      end
   endtask

   function automatic stim_t mk_box(input int o, input int iv,
                                    input int lo0, input int hi0,
                                    input int lo1, input int hi1,
                                    input int tmin, input int tmax);
      stim_t s;
      for (int a = 0; a < 3; a++) begin
         s.org[a]    = 16'(o);
         s.inv[a]    = 16'(iv);
         s.pl[a]     = 16'(lo0);
         s.pl[3+a]   = 16'(hi0);
         s.pl[6+a]   = 16'(lo1);
         s.pl[9+a]   = 16'(hi1);
      end
      s.tmin = 16'(tmin);
      s.tmax = 16'(tmax);
      s.tag  = 8'h00;
      s.lk0  = 32'h1000_0000;
      s.lk1  = 32'h2000_0000;
      return s;
   endfunction

   task automatic add_stim(input stim_t s);
      s.tag = 8'(pushed + stim_q.size() + 1);
      s.lk0 = s.lk0 ^ {24'h0, s.tag};
      s.lk1 = s.lk1 ^ {16'h0, s.tag, 8'h5A};
      stim_q.push_back(s);
   endtask

   function automatic stim_t rand_stim(input bit wide);
      stim_t s;
      int lo;
      for (int a = 0; a < 3; a++) begin
         if (wide) begin
            s.org[a] = 16'($urandom);
            s.inv[a] = 16'($urandom);
         end else begin
            s.org[a] = 16'($urandom_range(0, 2047) - 1024);
            s.inv[a] = 16'($urandom_range(0, 1023) - 512);
         end
      end
      for (int b = 0; b < 2; b++)
         for (int a = 0; a < 3; a++) begin
            lo = $urandom_range(0, 2047) - 1024;
            s.pl[b*6+a]   = 16'(lo);
            s.pl[b*6+3+a] = 16'(lo + $urandom_range(0, 1024));
         end
      s.tmin = ($urandom_range(0, 3) == 0) ? 16'($urandom_range(0, 512)) : 16'h0000;
      s.tmax = ($urandom_range(0, 3) == 0) ? 16'($urandom_range(0, 2048)) : 16'h7FFF;
      s.tag  = 8'h00;
      s.lk0  = $urandom;
      s.lk1  = $urandom;
      return s;
   endfunction

   task automatic run_until_empty(input int limit);
      for (int i = 0; i < limit; i++) begin
         if (stim_q.size() == 0 && !loaded && exp_q.size() == 0) break;
         step();
      end
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      check(1'b0, "R6", "watchdog expired", cyc, 0);
      finish_run();
   end

   initial begin : main
      stim_t s;
      repeat (3) @(negedge clk);
      // R10 during reset
      check(out_valid == 1'b0, "R10", "out_valid in reset", out_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      cyc++;
      #1;
      check(out_valid == 1'b0, "R10", "out_valid after reset", out_valid, 0);
      check(in_ready == 1'b1, "R10", "in_ready after reset", in_ready, 1);

      // directed cases, output always open, back to back (R8)
      ready_mode = 0;
      gap_pct    = 0;
      // box0 ahead, box1 behind the ray: only box0 hit
      add_stim(mk_box(0, 256, 256, 512, -512, -256, 0, 16'h7FFF));
      // both hit, box1 nearer: swap (R4)
      add_stim(mk_box(0, 256, 768, 1024, 256, 512, 0, 16'h7FFF));
      // equal entry: child 0 stays first (R4)
      add_stim(mk_box(0, 256, 256, 512, 256, 768, 0, 16'h7FFF));
      // touching at tmax: box0 hit with entry == exit, box1 miss (R2)
      add_stim(mk_box(0, 256, 256, 512, 384, 512, 0, 256));
      // negative inverse direction, ray travels towards smaller values (R1)
      add_stim(mk_box(0, -256, -512, -256, 256, 512, 0, 16'h7FFF));
      // extremes, no wrap (R9)
      add_stim(mk_box(-32768, -32768, 32767, 32767, -32768, 32767, -32768, 32767));
      add_stim(mk_box(32767, 32767, -32768, -32768, 32767, 32767, -32768, 32767));
      // box0 ahead, box1 behind with tmin cutting box1 (R1)
      add_stim(mk_box(0, 256, 256, 512, -256, 128, 256, 16'h7FFF));
      run_until_empty(100);

      // random traffic with open output and gaps
      gap_pct = 30;
      for (int i = 0; i < 150; i++) add_stim(rand_stim(i % 5 == 0));
      run_until_empty(2000);

      // random traffic with stalls on the output (R7)
      ready_mode = 1;
      gap_pct    = 10;
      for (int i = 0; i < 300; i++) add_stim(rand_stim(i % 4 == 0));
      run_until_empty(5000);

      ready_mode = 0;
      run_until_empty(20);
      check(exp_q.size() == 0, "R7", "pending results", exp_q.size(), 0);
      check(pushed == popped, "R7", "accepted vs delivered", popped, pushed);
      finish_run();
   end
endmodule